// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines, remembers each new request on its rising edge, and filters the requests through a programmable mask. The lowest-numbered unmasked pending line wins, and the single interrupt output to the processor is raised only when that winner outranks every line currently being serviced. Lower-priority and equal-priority requests are held until service ends, so nesting happens only for strictly more urgent sources.

The processor answers with a one-cycle acknowledge. The acknowledge moves the winning request into the in-service set and registers an interrupt vector equal to a base value plus the line number. Software ends service with a one-byte command that releases the most urgent in-service line. A second controller can be chained on a fixed input line. When that line is granted, a one-cycle strobe tells the system to take the vector from the chained device.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, int_o is low, vector_o is 0x00, cas_ack_o is low, the mask reads 0xFF (all lines blocked) and the in-service register reads 0x00.
- R2: A request is latched on a rising edge of its irq_i line, and int_o can rise on the next cycle. A line held high produces only one request until it falls and rises again.
- R3: Mask bit n set to 1 blocks line n, and 0 passes it. A blocked request stays pending and becomes visible as soon as its bit is cleared.
- R4: Among unmasked pending requests, the lowest line number wins.
- R5: int_o is asserted only when the winner's line number is strictly lower than every in-service line. Requests of equal or lower priority wait.
- R6: An ack_i while int_o is high clears the winner's request and sets its in-service bit. In the next cycle vector_o equals 0x08 plus the line number.
- R7: An ack_i while int_o is low changes neither the in-service register nor vector_o.
- R8: Writing 0x20 at address 0 clears the lowest-numbered set in-service bit. Any other value written at address 0 has no effect.
- R9: Address 1 is the mask register and can be written and read back. A read at address 0 returns the in-service register (bit n for line n).
- R10: Granting line 2, the chaining line, pulses cas_ack_o high for exactly the one cycle after the acknowledge. Granting any other line leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines, rising-edge sensitive |
| ack_i | input | 1 | Processor acknowledge, one cycle |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 command/in-service, 1 mask |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| int_o | output | 1 | Interrupt to processor |
| vector_o | output | 8 | Vector of the last granted line |
| cas_ack_o | output | 1 | Strobe: chained controller was granted |

## Verification
The properties assume that ack_i is a single-cycle pulse and that a write strobe is held for one cycle only. The bench pulses ack_i only from its acknowledge task and drives every strobe for exactly one clock. Irq lines are changed only between clock edges, so an edge is seen once. The bench also issues an acknowledge while no interrupt is pending, to cover the ignored case, and never raises a line whose earlier request is still unserviced.

// File: rtl/pic_pkg.sv
package pic_pkg;
  parameter int unsigned PIC_LINES = 8;
  localparam int unsigned PIC_IDX_W = $clog2(PIC_LINES);
  typedef logic [PIC_LINES-1:0] line_vec_t;
  typedef logic [PIC_IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  line_vec_t vec_i,
  output logic      any_o,
  output line_idx_t idx_o
);
  // lowest set index wins
  always_comb begin
    idx_o = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = PIC_IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/pic_req.sv
module pic_req
  import pic_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t irq_i,
  input  line_vec_t clr_i,
  output line_vec_t irr_o
);
  line_vec_t irq_q, irr_q, rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_q <= '0;
    end else begin
      irq_q <= irq_i;
      irr_q <= (irr_q & ~clr_i) | rise;
    end
  end

  assign irr_o = irr_q;

  // pending requests not granted survive (masked ones included)
  a_r3_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irr_q & $past(irr_q & ~clr_i)) == $past(irr_q & ~clr_i)));
endmodule

// File: rtl/pic_isr.sv
module pic_isr
  import pic_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t set_i,
  input  logic      eoi_i,
  output line_vec_t isr_o,
  output logic      any_o,
  output line_idx_t top_o
);
  line_vec_t isr_q, eoi_clr;

  pic_prio u_top (.vec_i(isr_q), .any_o(any_o), .idx_o(top_o));

  always_comb begin
    eoi_clr = '0;
    if (eoi_i && any_o) eoi_clr[top_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~eoi_clr) | set_i;
  end

  assign isr_o = isr_q;

  a_r8_eoi_releases_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (isr_q != '0) && (set_i == '0)) |=>
      ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter logic [7:0]  VEC_BASE = 8'h08,
  parameter int unsigned CAS_LINE = 2,
  parameter logic [7:0]  EOI_CODE = 8'h20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    irq_i,
  input  logic          ack_i,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          int_o,
  output logic [7:0]    vector_o,
  output logic          cas_ack_o
);
  localparam logic [7:0] CAS_VEC = VEC_BASE + 8'(CAS_LINE);

  line_vec_t irr, isr, mask_q, pending, grant_vec;
  line_idx_t win_idx, isr_top;
  logic      win_any, isr_any, grant, eoi;

  pic_req u_req (
    .clk_i (clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .clr_i (grant_vec), .irr_o(irr)
  );

  assign pending = irr & ~mask_q;

  pic_prio u_win (.vec_i(pending), .any_o(win_any), .idx_o(win_idx));

  pic_isr u_isr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(grant_vec), .eoi_i(eoi),
    .isr_o(isr), .any_o(isr_any), .top_o(isr_top)
  );

  // nest only above every in-service line
  assign int_o = win_any && (!isr_any || (win_idx < isr_top));
  assign grant = ack_i && int_o;
  assign eoi   = wr_i && !addr_i && (wdata_i[7:0] == EOI_CODE);

  always_comb begin
    grant_vec = '0;
    if (grant) grant_vec[win_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      vector_o  <= '0;
      cas_ack_o <= 1'b0;
    end else begin
      if (wr_i && addr_i) mask_q <= wdata_i[7:0];
      if (grant) vector_o <= VEC_BASE + 8'(win_idx);
      cas_ack_o <= grant && (32'(win_idx) == CAS_LINE);
    end
  end

  assign rdata_o = addr_i ? DW'(mask_q) : DW'(isr);

  a_r4_int_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask_q) != '0));
  a_r6_grant_enters_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !eoi) |=> ($countones(isr) == $past($countones(isr)) + 1));
  a_r7_spurious_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !eoi) |=> ($stable(isr) && $stable(vector_o)));
  a_r10_cas_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_ack_o |-> (vector_o == CAS_VEC));
endmodule

// File: tb/pic_ctrl_bench.sv
module pic_ctrl_bench;
  logic       clk_i = 0, rst_ni = 0;
  logic [7:0] irq_i = '0, wdata_i = '0;
  logic       ack_i = 0, wr_i = 0, addr_i = 0;
  logic [7:0] rdata_o, vector_o;
  logic       int_o, cas_ack_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  pic_ctrl u_pic_ctrl (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    addr_i = a; #1;
    chk(rdata_o == exp, tag, rdata_o, exp);
  endtask

  task automatic raise(input int n);
    @(negedge clk_i); irq_i[n] = 1;
    @(negedge clk_i);
  endtask

  task automatic lower(input int n);
    @(negedge clk_i); irq_i[n] = 0;
    @(negedge clk_i);
  endtask

  task automatic ack(input logic [7:0] exp);
    @(negedge clk_i); exp_q.push_back(exp); ack_i = 1;
    @(negedge clk_i); ack_i = 0;
  endtask

  // monitor: compare vector after each acknowledge
  initial forever begin
    @(posedge clk_i);
    if (ack_i && exp_q.size() > 0) begin
      @(negedge clk_i);
      begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(vector_o == e, "R6 vector", vector_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(int_o == 0, "R1 int", int_o, 0);
    chk(vector_o == 0, "R1 vector", vector_o, 0);
    chk(cas_ack_o == 0, "R1 cas", cas_ack_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    rd(1, 8'hFF, "R1 mask");
    rd(0, 8'h00, "R1 isr");
    // R9 mask read/write
    wr(1, 8'hA5); rd(1, 8'hA5, "R9 mask rw");
    wr(1, 8'h00); rd(1, 8'h00, "R9 mask clr");
    // R2 edge latch, R6 grant
    raise(5);
    chk(int_o == 1, "R2 int after edge", int_o, 1);
    ack(8'h0D);
    @(negedge clk_i);
    rd(0, 8'h20, "R6 isr line5");
    chk(int_o == 0, "R6 int drop", int_o, 0);
    // R5 nesting
    raise(6);
    chk(int_o == 0, "R5 lower held", int_o, 1'b0);
    raise(3);
    chk(int_o == 1, "R5 higher nests", int_o, 1);
    ack(8'h0B);
    @(negedge clk_i);
    rd(0, 8'h28, "R6 isr nested");
    chk(int_o == 0, "R5 line6 waits", int_o, 0);
    // R8 EOI
    wr(0, 8'h20); rd(0, 8'h20, "R8 eoi clears line3");
    chk(int_o == 0, "R5 line6 below line5", int_o, 0);
    wr(0, 8'h11); rd(0, 8'h20, "R8 other code ignored");
    wr(0, 8'h20); rd(0, 8'h00, "R8 eoi clears line5");
    chk(int_o == 1, "R5 line6 released", int_o, 1);
    ack(8'h0E);
    wr(0, 8'h20);
    lower(5); lower(6); lower(3);
    // R3 masked request held
    wr(1, 8'h02);
    raise(1);
    chk(int_o == 0, "R3 masked", int_o, 0);
    lower(1);
    wr(1, 8'h00);
    chk(int_o == 1, "R3 pending kept", int_o, 1);
    ack(8'h09);
    wr(0, 8'h20);
    // R2 level held: one request only
    raise(4);
    ack(8'h0C);
    wr(0, 8'h20);
    repeat (3) @(negedge clk_i);
    chk(int_o == 0, "R2 no retrigger", int_o, 0);
    lower(4); raise(4);
    chk(int_o == 1, "R2 new edge", int_o, 1);
    ack(8'h0C);
    wr(0, 8'h20); lower(4);
    // R4 simultaneous
    @(negedge clk_i); irq_i[7] = 1; irq_i[0] = 1; irq_i[4] = 1;
    @(negedge clk_i);
    ack(8'h08);
    wr(0, 8'h20);
    ack(8'h0C);
    wr(0, 8'h20);
    ack(8'h0F);
    wr(0, 8'h20);
    rd(0, 8'h00, "R4 all served");
    irq_i = '0;
    @(negedge clk_i);
    // R7 spurious ack
    chk(int_o == 0, "R7 idle", int_o, 0);
    @(negedge clk_i); ack_i = 1;
    @(negedge clk_i); ack_i = 0;
    chk(vector_o == 8'h0F, "R7 vector kept", vector_o, 8'h0F);
    rd(0, 8'h00, "R7 isr kept");
    // R10 cascade strobe
    raise(2);
    ack(8'h0A);
    chk(cas_ack_o == 1, "R10 cas pulse", cas_ack_o, 1);
    @(negedge clk_i);
    chk(cas_ack_o == 0, "R10 cas one cycle", cas_ack_o, 0);
    wr(0, 8'h20); lower(2);
    raise(6);
    ack(8'h0E);
    chk(cas_ack_o == 0, "R10 no cas other line", cas_ack_o, 0);
    wr(0, 8'h20);
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule